// File: doc/BRIEF.md
# Keyed Configuration Register Gate

This block is the configuration front end of a multi-function I/O controller. A host reaches it over a simple byte-wide bus through two adjacent addresses. The even address is an index port and the next address is a data port. The configuration registers stay out of reach until the host writes a two-byte key to the index port. After that, the host writes an index and then the value that register should take. A distinct exit byte on the index port closes access again.

A global select register chooses which logical device the per-device registers refer to. Each logical device has its own bank:

- an activate bit
- two 16-bit base addresses
- an interrupt number and its trigger type
- two DMA channel numbers
- a mode byte

All banks drive their values out of the block in parallel. The peripherals that use those values live elsewhere.

Top module: `cfg_gate_top`

## Requirements
- R1: Configuration mode (`cfg_mode` = 1) is entered only after two consecutive index-port writes of 0x87. `cfg_mode` rises on the clock edge after the second such write.
- R2: While locked, an index-port write of any value other than 0x87 restarts the key sequence. Data-port writes, and cycles with no write, do not restart it.
- R3: An index-port write of 0xAA in configuration mode clears `cfg_mode` on the next edge. Index and data writes made while locked change no register and no output.
- R4: A read of either port while locked returns 0xFF. Every read result appears on `rd_data` one clock after the cycle in which `rd_en` is high, and `rd_data` holds its value when no read occurs.
- R5: The index port is at address BASE_ADDR, which is even, and the data port is at BASE_ADDR+1. Accesses to any other address have no effect. An index-port read in configuration mode returns the current index.
- R6: Register 0x07 holds the logical device number and reads back as written. Writes to index 0x30 or above reach only the bank of that device. When the number is NDEV or larger, such writes are dropped and reads of index 0x30 or above return 0x00.
- R7: Bit 0 of register 0x30 drives `dev_active` for the device; 0x00 deactivates it. The register reads back as {7'b0, bit 0}.
- R8: Registers 0x60 (high byte) and 0x61 (low byte) form `dev_base0`. Registers 0x62 (high) and 0x63 (low) form `dev_base1`. Each device's 16-bit slice sits at bits [16*d+15:16*d].
- R9: Register 0x70 drives `dev_irq`. In register 0x71, bit 1 = 1 means active high (`dev_irq_high`) and bit 0 = 1 means level triggered (`dev_irq_level`), so 0x02 means active-high edge. Both registers read back all 8 bits.
- R10: Registers 0x74 and 0x75 drive `dev_dma0` and `dev_dma1`. A `_used` flag is high only when the value is below 0x04; 0x04 means no channel.
- R11: After reset the block is locked, all devices are inactive, every bank register reads 0x00, the index and device number are 0, and `rd_data` is 0xFF.
- R12: Register 0xF0 drives `dev_mode`. Every other index below 0x30 except 0x07, and every unlisted index of 0x30 or above, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte bus address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while configuration access is open |
| dev_active | output | NDEV | Per-device activate bit |
| dev_base0 | output | NDEV*16 | Per-device first base address |
| dev_base1 | output | NDEV*16 | Per-device second base address |
| dev_irq | output | NDEV*8 | Per-device interrupt number |
| dev_irq_high | output | NDEV | Interrupt active high |
| dev_irq_level | output | NDEV | Interrupt level triggered |
| dev_dma0 | output | NDEV*8 | First DMA channel value |
| dev_dma0_used | output | NDEV | First DMA channel in use |
| dev_dma1 | output | NDEV*8 | Second DMA channel value |
| dev_dma1_used | output | NDEV | Second DMA channel in use |
| dev_mode | output | NDEV*8 | Per-device mode byte |

## Verification
The bench breaks the key with a stray index byte and expects the block to stay locked. A design that only counted 0x87 bytes would open here. It also places a data-port write between the two key bytes, which must not break the key. It sweeps every device, writing distinct values that are computed arithmetically, and reads them back. It then sweeps every unimplemented index. Bank crosstalk, a swapped high and low base byte, or a write landing in a hole would each appear as a wrong byte on some output or readback. Finally it selects a device number beyond the last bank and writes through the off-range address and after the exit byte. Each of these writes must leave all outputs unchanged, which catches missing range or lock guards.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_BANK0 = 8'h30;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_B0H   = 8'h60;
  localparam logic [7:0] IDX_B0L   = 8'h61;
  localparam logic [7:0] IDX_B1H   = 8'h62;
  localparam logic [7:0] IDX_B1L   = 8'h63;
  localparam logic [7:0] IDX_IRQ   = 8'h70;
  localparam logic [7:0] IDX_IRQT  = 8'h71;
  localparam logic [7:0] IDX_DMA0  = 8'h74;
  localparam logic [7:0] IDX_DMA1  = 8'h75;
  localparam logic [7:0] IDX_MODE  = 8'hF0;
  localparam logic [7:0] DMA_NONE  = 8'h04;
  localparam logic [7:0] RD_LOCKED = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } gate_st_t;
endpackage

// File: rtl/cfg_unlock.sv
module cfg_unlock
  import cfg_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_mode
);
  gate_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        ST_LOCKED: st_d = (wdata == KEY_ENTER) ? ST_HALF : ST_LOCKED;
        ST_HALF:   st_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   st_d = (wdata == KEY_EXIT)  ? ST_LOCKED : ST_OPEN;
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_LOCKED;
    else     st_q <= st_d;
  end

  assign cfg_mode = (st_q == ST_OPEN);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_byte,
  output logic        act,
  output logic [15:0] base0,
  output logic [15:0] base1,
  output logic [7:0]  irq,
  output logic        irq_high,
  output logic        irq_level,
  output logic [7:0]  dma0,
  output logic        dma0_used,
  output logic [7:0]  dma1,
  output logic        dma1_used,
  output logic [7:0]  mode
);
  logic [7:0] irqt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      base0 <= '0;
      base1 <= '0;
      irq   <= '0;
      irqt  <= '0;
      dma0  <= '0;
      dma1  <= '0;
      mode  <= '0;
    end else if (we) begin
      case (idx)
        IDX_ACT:  act          <= wdata[0];
        IDX_B0H:  base0[15:8]  <= wdata;
        IDX_B0L:  base0[7:0]   <= wdata;
        IDX_B1H:  base1[15:8]  <= wdata;
        IDX_B1L:  base1[7:0]   <= wdata;
        IDX_IRQ:  irq          <= wdata;
        IDX_IRQT: irqt         <= wdata;
        IDX_DMA0: dma0         <= wdata;
        IDX_DMA1: dma1         <= wdata;
        IDX_MODE: mode         <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_ACT:  rd_byte = {7'b0, act};
      IDX_B0H:  rd_byte = base0[15:8];
      IDX_B0L:  rd_byte = base0[7:0];
      IDX_B1H:  rd_byte = base1[15:8];
      IDX_B1L:  rd_byte = base1[7:0];
      IDX_IRQ:  rd_byte = irq;
      IDX_IRQT: rd_byte = irqt;
      IDX_DMA0: rd_byte = dma0;
      IDX_DMA1: rd_byte = dma1;
      IDX_MODE: rd_byte = mode;
      default:  rd_byte = 8'h00;
    endcase
  end

  assign irq_high  = irqt[1];
  assign irq_level = irqt[0];
  assign dma0_used = (dma0 < DMA_NONE);
  assign dma1_used = (dma1 < DMA_NONE);
endmodule

// File: rtl/cfg_gate_top.sv
module cfg_gate_top
  import cfg_gate_pkg::*;
#(
  parameter int              NDEV      = 8,
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h370
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  output logic                 cfg_mode,
  output logic [NDEV-1:0]      dev_active,
  output logic [NDEV*16-1:0]   dev_base0,
  output logic [NDEV*16-1:0]   dev_base1,
  output logic [NDEV*8-1:0]    dev_irq,
  output logic [NDEV-1:0]      dev_irq_high,
  output logic [NDEV-1:0]      dev_irq_level,
  output logic [NDEV*8-1:0]    dev_dma0,
  output logic [NDEV-1:0]      dev_dma0_used,
  output logic [NDEV*8-1:0]    dev_dma1,
  output logic [NDEV-1:0]      dev_dma1_used,
  output logic [NDEV*8-1:0]    dev_mode
);
  localparam int         SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [7:0] NDEV_B = 8'(NDEV);

  logic       hit, is_idx, is_data;
  logic [7:0] idx_q, ldn_q;
  logic       ldn_ok;
  logic [7:0] sel_byte;
  logic [7:0] bank_rd [NDEV];

  assign hit     = (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign is_idx  = hit & ~bus_addr[0];
  assign is_data = hit &  bus_addr[0];
  assign ldn_ok  = (ldn_q < NDEV_B);

  cfg_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (wr_en & is_idx),
    .wdata    (wr_data),
    .cfg_mode (cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else if (cfg_mode && wr_en) begin
      if (is_idx && wr_data != KEY_EXIT) idx_q <= wr_data;
      if (is_data && idx_q == IDX_LDN)   ldn_q <= wr_data;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_bank
    logic we_d;
    assign we_d = cfg_mode & wr_en & is_data & (idx_q >= IDX_BANK0) & (ldn_q == 8'(d));

    cfg_bank u_bank (
      .clk       (clk),
      .rst       (rst),
      .we        (we_d),
      .idx       (idx_q),
      .wdata     (wr_data),
      .rd_byte   (bank_rd[d]),
      .act       (dev_active[d]),
      .base0     (dev_base0[16*d +: 16]),
      .base1     (dev_base1[16*d +: 16]),
      .irq       (dev_irq[8*d +: 8]),
      .irq_high  (dev_irq_high[d]),
      .irq_level (dev_irq_level[d]),
      .dma0      (dev_dma0[8*d +: 8]),
      .dma0_used (dev_dma0_used[d]),
      .dma1      (dev_dma1[8*d +: 8]),
      .dma1_used (dev_dma1_used[d]),
      .mode      (dev_mode[8*d +: 8])
    );
  end

  always_comb begin
    if (idx_q == IDX_LDN)                  sel_byte = ldn_q;
    else if (idx_q >= IDX_BANK0 && ldn_ok) sel_byte = bank_rd[ldn_q[SEL_W-1:0]];
    else                                   sel_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)                rd_data <= RD_LOCKED;
    else if (rd_en && hit)  rd_data <= !cfg_mode ? RD_LOCKED : (bus_addr[0] ? sel_byte : idx_q);
  end
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk #(
  parameter int                NDEV      = 8,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h370
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              cfg_mode,
  input logic [NDEV-1:0]   dev_active
);
  logic at_idx, at_any;
  assign at_idx = (bus_addr == BASE_ADDR);
  assign at_any = (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

  AST_ENTER_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(wr_en && at_idx && wr_data == 8'h87)); // R1

  AST_EXIT_KEY: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && wr_en && at_idx && wr_data == 8'hAA) |=> !cfg_mode); // R3

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> $stable(dev_active)); // R3

  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_any && !cfg_mode) |=> (rd_data == 8'hFF)); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && at_any) |=> $stable(rd_data)); // R4
endmodule

bind cfg_gate_top cfg_gate_chk #(
  .NDEV(NDEV), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .cfg_mode(cfg_mode), .dev_active(dev_active)
);

// File: tb/sim_cfg_gate_top.sv
module sim_cfg_gate_top;
  localparam int         NDEV  = 4;
  localparam int         AW    = 12;
  localparam logic [11:0] BASE = 12'h370;
  localparam logic [11:0] IDXP = BASE;
  localparam logic [11:0] DATP = BASE + 12'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cfg_mode;
  logic [NDEV-1:0] dev_active, dev_irq_high, dev_irq_level, dev_dma0_used, dev_dma1_used;
  logic [NDEV*16-1:0] dev_base0, dev_base1;
  logic [NDEV*8-1:0] dev_irq, dev_dma0, dev_dma1, dev_mode;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cfg_gate_top #(.NDEV(NDEV), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_mode(cfg_mode),
    .dev_active(dev_active), .dev_base0(dev_base0), .dev_base1(dev_base1),
    .dev_irq(dev_irq), .dev_irq_high(dev_irq_high), .dev_irq_level(dev_irq_level),
    .dev_dma0(dev_dma0), .dev_dma0_used(dev_dma0_used),
    .dev_dma1(dev_dma1), .dev_dma1_used(dev_dma1_used), .dev_mode(dev_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    bus_wr(IDXP, i);
    bus_wr(DATP, v);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    bus_wr(IDXP, i);
    bus_rd(DATP, v);
  endtask

  function automatic logic [7:0] pat(input int d, input int k);
    return 8'((d * 53 + k * 29 + 17) & 255);
  endfunction

  function automatic logic [7:0] act_wr(input int d);
    return (d % 2 == 1) ? 8'hFF : 8'hFE;
  endfunction

  function automatic logic [7:0] dma_pat(input int d, input int ch);
    return (ch == 0) ? 8'(d + 2) : 8'(4 - d);
  endfunction

  function automatic bit implemented(input logic [7:0] i);
    return i == 8'h07 || i == 8'h30 || (i >= 8'h60 && i <= 8'h63) ||
           i == 8'h70 || i == 8'h71 || i == 8'h74 || i == 8'h75 || i == 8'hF0;
  endfunction

  task automatic check_dev(input int d, input string tag);
    chk({tag, " R7 active"}, 32'(dev_active[d]), 32'(d % 2));
    chk({tag, " R8 base0"}, 32'(dev_base0[16*d +: 16]), {16'h0, pat(d, 0), pat(d, 1)});
    chk({tag, " R8 base1"}, 32'(dev_base1[16*d +: 16]), {16'h0, pat(d, 2), pat(d, 3)});
    chk({tag, " R9 irq"}, 32'(dev_irq[8*d +: 8]), 32'(pat(d, 4)));
    chk({tag, " R9 high"}, 32'(dev_irq_high[d]), 32'(d < 2));
    chk({tag, " R9 level"}, 32'(dev_irq_level[d]), 32'(d % 2));
    chk({tag, " R10 dma0"}, 32'(dev_dma0[8*d +: 8]), 32'(dma_pat(d, 0)));
    chk({tag, " R10 dma0_used"}, 32'(dev_dma0_used[d]), 32'(dma_pat(d, 0) < 8'h04));
    chk({tag, " R10 dma1"}, 32'(dev_dma1[8*d +: 8]), 32'(dma_pat(d, 1)));
    chk({tag, " R10 dma1_used"}, 32'(dev_dma1_used[d]), 32'(dma_pat(d, 1) < 8'h04));
    chk({tag, " R12 mode"}, 32'(dev_mode[8*d +: 8]), 32'(pat(d, 5)));
  endtask

  task automatic check_all(input string tag);
    for (int d = 0; d < NDEV; d++) check_dev(d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 cfg_mode", 32'(cfg_mode), 0);
    chk("R11 rd_data", 32'(rd_data), 32'hFF);
    chk("R11 active", 32'(dev_active), 0);
    chk("R11 base0", 32'(dev_base0), 0);
    // R4 locked reads
    bus_rd(DATP, v); chk("R4 locked data read", 32'(v), 32'hFF);
    bus_rd(IDXP, v); chk("R4 locked index read", 32'(v), 32'hFF);
    // R3 locked writes ignored
    reg_wr(8'h30, 8'h01);
    chk("R3 locked write", 32'(dev_active), 0);
    // R2 broken key
    bus_wr(IDXP, 8'h87); bus_wr(IDXP, 8'h00); bus_wr(IDXP, 8'h87);
    chk("R2 broken key stays locked", 32'(cfg_mode), 0);
    bus_wr(IDXP, 8'h55);
    // R1 / R2 key with data write between
    bus_wr(IDXP, 8'h87);
    chk("R1 one key byte", 32'(cfg_mode), 0);
    bus_wr(DATP, 8'h33);
    bus_wr(IDXP, 8'h87);
    chk("R1 R2 open after key", 32'(cfg_mode), 1);
    // R11 bank zero after reset, R5 index readback
    reg_rd(8'h70, v); chk("R11 bank zero", 32'(v), 0);
    bus_rd(IDXP, v); chk("R5 index readback", 32'(v), 32'h70);
    // R5 off-range address ignored
    bus_wr(BASE + 12'd2, 8'h61);
    bus_wr(BASE - 12'd2, 8'h62);
    bus_rd(IDXP, v); chk("R5 off-range index write", 32'(v), 32'h70);
    bus_wr(BASE + 12'd3, 8'h12);
    reg_rd(8'h70, v); chk("R5 off-range data write", 32'(v), 0);
    // sweep all devices
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_wr(8'h30, act_wr(d));
      reg_wr(8'h60, pat(d, 0)); reg_wr(8'h61, pat(d, 1));
      reg_wr(8'h62, pat(d, 2)); reg_wr(8'h63, pat(d, 3));
      reg_wr(8'h70, pat(d, 4));
      reg_wr(8'h71, {6'b0, d < 2, d % 2 == 1});
      reg_wr(8'h74, dma_pat(d, 0)); reg_wr(8'h75, dma_pat(d, 1));
      reg_wr(8'hF0, pat(d, 5));
    end
    check_all("sweep");
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h07, v); chk("R6 ldn readback", 32'(v), 32'(d));
      reg_rd(8'h30, v); chk("R7 act readback", 32'(v), 32'(d % 2));
      reg_rd(8'h60, v); chk("R8 base0 hi", 32'(v), 32'(pat(d, 0)));
      reg_rd(8'h61, v); chk("R8 base0 lo", 32'(v), 32'(pat(d, 1)));
      reg_rd(8'h62, v); chk("R8 base1 hi", 32'(v), 32'(pat(d, 2)));
      reg_rd(8'h63, v); chk("R8 base1 lo", 32'(v), 32'(pat(d, 3)));
      reg_rd(8'h70, v); chk("R9 irq readback", 32'(v), 32'(pat(d, 4)));
      reg_rd(8'h71, v); chk("R9 type readback", 32'(v), 32'({6'b0, d < 2, d % 2 == 1}));
      reg_rd(8'h74, v); chk("R10 dma0 readback", 32'(v), 32'(dma_pat(d, 0)));
      reg_rd(8'h75, v); chk("R10 dma1 readback", 32'(v), 32'(dma_pat(d, 1)));
      reg_rd(8'hF0, v); chk("R12 mode readback", 32'(v), 32'(pat(d, 5)));
    end
    // R6 out-of-range device number
    reg_wr(8'h07, 8'(NDEV + 1));
    reg_wr(8'h70, 8'hC3);
    reg_wr(8'h30, 8'h00);
    reg_rd(8'h70, v); chk("R6 out-of-range read", 32'(v), 0);
    check_all("R6 out-of-range write");
    // R12 holes sweep on device 1
    reg_wr(8'h07, 8'd1);
    for (int i = 0; i < 256; i++) begin
      if (!implemented(8'(i)) && i != 8'hAA) begin
        reg_wr(8'(i), 8'h5A);
        reg_rd(8'(i), v);
        if (v !== 8'h00) chk("R12 hole read", {24'h0, 8'(i)}, {24'h0, 8'(i) ^ 8'hFF});
      end
    end
    chk("R12 hole sweep done", 32'(cfg_mode), 1);
    check_all("R12 holes");
    // R3 exit and locked writes
    bus_wr(IDXP, 8'hAA);
    chk("R3 exit", 32'(cfg_mode), 0);
    bus_rd(DATP, v); chk("R4 read after exit", 32'(v), 32'hFF);
    bus_wr(DATP, 8'h00);
    bus_wr(IDXP, 8'h30); bus_wr(DATP, 8'h00);
    check_all("R3 after exit");
    bus_wr(IDXP, 8'h87); bus_wr(IDXP, 8'h87);
    chk("R1 reentry", 32'(cfg_mode), 1);
    reg_rd(8'h07, v); chk("R3 ldn kept", 32'(v), 1);
    reg_rd(8'h30, v); chk("R3 act kept", 32'(v), 1);
    // R7 deactivate
    reg_wr(8'h30, 8'h00);
    chk("R7 deactivate", 32'(dev_active), 32'b1000);
    // R11 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R11 reset locks", 32'(cfg_mode), 0);
    chk("R11 reset clears", 32'(dev_irq), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule